// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a 32-word by 16-bit circular data buffer. It sits between a host register port and a card data engine. Either side can push words into it and pop words out of it. The buffer compares its fill count with two programmable thresholds: a high-water level used when data moves from the card to the host, and a low-water level used when data moves from the host to the card. For each direction, a mode bit chooses how the crossing is reported. In DMA mode a level request line is driven to the DMA controller. In flag mode a level status flag is raised instead.

The thresholds and mode bits come from one 16-bit buffer-configuration word, which reads back in the same layout. The level logic is evaluated only while a transfer is active or the buffer still holds data. When neither is true, every request and flag stays low. Only the direction selected by `xfer_rd` can raise its request or flag. The output for the other direction is held low.

Top module: `thresh_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `empty` is 1 and `full` is 0. `cfg_rdata` reads 0x1F00 (high-water 31, low-water 0, both DMA modes off), and all four level outputs are 0.
- R2: Words leave the buffer in the order they were accepted. `head_data` always shows the oldest stored word. `fill_count`, `full` (count = 32) and `empty` (count = 0) track every accepted push and pop.
- R3: A push made while 32 words are stored is dropped. The count stays 32 and the stored words are unchanged.
- R4: A pop made while the buffer is empty leaves the count at 0 and leaves `head_data` unchanged.
- R5: The configuration word has these fields: RX-DMA enable at bit 15, high-water level at bits 12:8, TX-DMA enable at bit 7, low-water level at bits 4:0. Other bits are ignored and read as 0. A write takes effect on the next cycle and reads back in the same layout.
- R6: The card-to-host condition is: `xfer_rd`=1, level logic active, and count greater than the high-water level. When the condition holds, `rx_dma_req` is 1 if RX-DMA is enabled; otherwise `af_flag` is 1. When it does not hold, both are 0. Enabling RX-DMA clears `af_flag` on the cycle the write takes effect.
- R7: The host-to-card condition is: `xfer_rd`=0, level logic active, and count less than the low-water level. When the condition holds, `tx_dma_req` is 1 if TX-DMA is enabled; otherwise `ae_flag` is 1. When it does not hold, both are 0. Enabling TX-DMA clears `ae_flag` on the cycle the write takes effect.
- R8: With `xfer_active`=0 and the buffer empty, all four level outputs are 0.
- R9: While `xfer_rd`=1, `tx_dma_req` and `ae_flag` are 0. While `xfer_rd`=0, `rx_dma_req` and `af_flag` are 0.
- R10: Acceptance is judged on the count before the edge. A push is accepted only below 32 words, and a pop only above 0. A push and a pop accepted on the same edge leave the count unchanged.
- R11: When the host and the engine push on the same edge, one word is stored and it is `host_wdata`. Simultaneous pops remove one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the buffer-configuration word |
| cfg_wdata | input | 16 | Configuration value to write |
| cfg_rdata | output | 16 | Current configuration word |
| host_push | input | 1 | Host pushes `host_wdata` |
| host_wdata | input | 16 | Host push data |
| host_pop | input | 1 | Host pops the head word |
| eng_push | input | 1 | Engine pushes `eng_wdata` |
| eng_wdata | input | 16 | Engine push data |
| eng_pop | input | 1 | Engine pops the head word |
| head_data | output | 16 | Oldest stored word |
| xfer_active | input | 1 | A transfer is in progress |
| xfer_rd | input | 1 | 1: card to host, 0: host to card |
| rx_dma_req | output | 1 | Card-to-host DMA request level |
| tx_dma_req | output | 1 | Host-to-card DMA request level |
| af_flag | output | 1 | High-water status flag |
| ae_flag | output | 1 | Low-water status flag |
| fill_count | output | 6 | Number of stored words, 0 to 32 |
| full | output | 1 | 32 words stored |
| empty | output | 1 | No word stored |

## Verification
Every result is due in the cycle that follows the rising edge that samples the stimulus: `fill_count`, `full`, `empty` and `head_data` after a push or pop, and `cfg_rdata` after a configuration write. The four level outputs are decoded from registered state without further delay, so they follow the new count or configuration from that same edge, and a change on `xfer_active` or `xfer_rd` shows up at once. The bench drives inputs just after a falling edge and compares all outputs at the next falling edge, half a period after the rising edge. At that point its reference model has already absorbed the stimulus.

// File: rtl/thresh_fifo_pkg.sv
package thresh_fifo_pkg;
  // Buffer-configuration word layout (register-visible, fixed positions)
  localparam int CFG_W     = 16;
  localparam int RXEN_BIT  = 15;
  localparam int HIWAT_LSB = 8;
  localparam int TXEN_BIT  = 7;
  localparam int LOWAT_LSB = 0;
  localparam int LVL_W     = 5;

  typedef struct packed {
    logic             rx_en;
    logic [LVL_W-1:0] hi_lvl;
    logic             tx_en;
    logic [LVL_W-1:0] lo_lvl;
  } buf_cfg_t;
endpackage

// File: rtl/thresh_fifo_cfg.sv
module thresh_fifo_cfg
  import thresh_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output buf_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  buf_cfg_t cfg_q, cfg_d;
  logic     unused_cfg_bits;

  assign unused_cfg_bits = ^{wdata[14:13], wdata[6:5]};

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.rx_en  = wdata[RXEN_BIT];
      cfg_d.hi_lvl = wdata[HIWAT_LSB +: LVL_W];
      cfg_d.tx_en  = wdata[TXEN_BIT];
      cfg_d.lo_lvl = wdata[LOWAT_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.rx_en  <= 1'b0;
      cfg_q.hi_lvl <= '1;
      cfg_q.tx_en  <= 1'b0;
      cfg_q.lo_lvl <= '0;
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rdata                        = '0;
    rdata[RXEN_BIT]              = cfg_q.rx_en;
    rdata[HIWAT_LSB +: LVL_W]    = cfg_q.hi_lvl;
    rdata[TXEN_BIT]              = cfg_q.tx_en;
    rdata[LOWAT_LSB +: LVL_W]    = cfg_q.lo_lvl;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/thresh_fifo_store.sv
module thresh_fifo_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, tail;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  // DEPTH is a power of two, so the sum wraps naturally
  assign tail    = head_q + cnt_q[PTR_W-1:0];

  always_comb begin
    head_d = head_q;
    cnt_d  = cnt_q;
    if (pop_ok) head_d = head_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (push_ok || pop_ok) begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (push_ok && (tail == PTR_W'(i))) mem[i] <= wdata;
    end
  end

  assign head_data = mem[head_q];
  assign count     = cnt_q;
endmodule

// File: rtl/thresh_fifo_level.sv
module thresh_fifo_level
  import thresh_fifo_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  buf_cfg_t         cfg,
  input  logic [CNT_W-1:0] count,
  input  logic             active,
  input  logic             dir_rd,
  output logic             rx_req,
  output logic             tx_req,
  output logic             hi_flag,
  output logic             lo_flag
);
  logic live, hi_hit, lo_hit;

  always_comb begin
    live    = active || (count != '0);
    hi_hit  = live && dir_rd  && (count > CNT_W'(cfg.hi_lvl));
    lo_hit  = live && !dir_rd && (count < CNT_W'(cfg.lo_lvl));
    rx_req  = hi_hit && cfg.rx_en;
    hi_flag = hi_hit && !cfg.rx_en;
    tx_req  = lo_hit && cfg.tx_en;
    lo_flag = lo_hit && !cfg.tx_en;
  end
endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo
  import thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             host_push,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_pop,
  input  logic             eng_push,
  input  logic [WIDTH-1:0] eng_wdata,
  input  logic             eng_pop,
  output logic [WIDTH-1:0] head_data,
  input  logic             xfer_active,
  input  logic             xfer_rd,
  output logic             rx_dma_req,
  output logic             tx_dma_req,
  output logic             af_flag,
  output logic             ae_flag,
  output logic [CNT_W-1:0] fill_count,
  output logic             full,
  output logic             empty
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  buf_cfg_t         cfg;
  logic             push, pop;
  logic [WIDTH-1:0] push_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // host side wins when both sides present data together
  assign push      = host_push || eng_push;
  assign push_data = host_push ? host_wdata : eng_wdata;
  assign pop       = host_pop || eng_pop;

  thresh_fifo_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  thresh_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .wdata     (push_data),
    .pop       (pop),
    .head_data (head_data),
    .count     (fill_count),
    .full      (full),
    .empty     (empty)
  );

  thresh_fifo_level #(.CNT_W(CNT_W)) u_level (
    .cfg     (cfg),
    .count   (fill_count),
    .active  (xfer_active),
    .dir_rd  (xfer_rd),
    .rx_req  (rx_dma_req),
    .tx_req  (tx_dma_req),
    .hi_flag (af_flag),
    .lo_flag (ae_flag)
  );
endmodule

// File: rtl/thresh_fifo_chk.sv
module thresh_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [15:0] cfg_rdata,
  input logic        host_push,
  input logic        eng_push,
  input logic        host_pop,
  input logic        eng_pop,
  input logic        xfer_active,
  input logic        xfer_rd,
  input logic        rx_dma_req,
  input logic        tx_dma_req,
  input logic        af_flag,
  input logic        ae_flag,
  input logic [5:0]  fill_count,
  input logic        full,
  input logic        empty
);
  logic any_push, any_pop;
  assign any_push = host_push || eng_push;
  assign any_pop  = host_pop || eng_pop;

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= 6'd32);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full && any_push && !any_pop |=> full && $stable(fill_count));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty && any_pop && !any_push |=> empty);

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  a_r6_rx_req_mode: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> cfg_rdata[15] && xfer_rd && !af_flag);

  a_r7_tx_req_mode: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> cfg_rdata[7] && !xfer_rd && !ae_flag);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active && empty |-> !(rx_dma_req || tx_dma_req || af_flag || ae_flag));

  a_r9_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_dma_req || af_flag, tx_dma_req || ae_flag}) <= 1);

  a_r10_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    any_push && any_pop && !full && !empty |=> $stable(fill_count));
endmodule

bind thresh_fifo thresh_fifo_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_rdata   (cfg_rdata),
  .host_push   (host_push),
  .eng_push    (eng_push),
  .host_pop    (host_pop),
  .eng_pop     (eng_pop),
  .xfer_active (xfer_active),
  .xfer_rd     (xfer_rd),
  .rx_dma_req  (rx_dma_req),
  .tx_dma_req  (tx_dma_req),
  .af_flag     (af_flag),
  .ae_flag     (ae_flag),
  .fill_count  (fill_count),
  .full        (full),
  .empty       (empty)
);

// File: tb/thresh_fifo_test.sv
module thresh_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        host_push, host_pop, eng_push, eng_pop;
  logic [15:0] host_wdata, eng_wdata, head_data;
  logic        xfer_active, xfer_rd;
  logic        rx_dma_req, tx_dma_req, af_flag, ae_flag;
  logic [5:0]  fill_count;
  logic        full, empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [15:0] q[$];
  bit          m_rx_en, m_tx_en;
  int          m_hi, m_lo;

  always #10 clk = ~clk;

  thresh_fifo uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hi_hit();
    int n = q.size();
    return (xfer_active || n != 0) && xfer_rd && (n > m_hi);
  endfunction

  function automatic bit exp_lo_hit();
    int n = q.size();
    return (xfer_active || n != 0) && !xfer_rd && (n < m_lo);
  endfunction

  function automatic int exp_cfg();
    return (int'(m_rx_en) << 15) | (m_hi << 8) | (int'(m_tx_en) << 7) | m_lo;
  endfunction

  task automatic check_all(string ctx);
    chk({ctx, " R2 count"}, fill_count, q.size());
    chk({ctx, " R2 full"},  full,  q.size() == 32);
    chk({ctx, " R2 empty"}, empty, q.size() == 0);
    if (q.size() > 0) chk({ctx, " R2 head"}, head_data, q[0]);
    chk({ctx, " R5 cfg"}, cfg_rdata, exp_cfg());
    chk({ctx, " R6 rx_req"}, rx_dma_req, exp_hi_hit() && m_rx_en);
    chk({ctx, " R6 af_flag"}, af_flag, exp_hi_hit() && !m_rx_en);
    chk({ctx, " R7 tx_req"}, tx_dma_req, exp_lo_hit() && m_tx_en);
    chk({ctx, " R7 ae_flag"}, ae_flag, exp_lo_hit() && !m_tx_en);
  endtask

  task automatic idle_inputs();
    cfg_we = 0; host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0;
  endtask

  // absorb the driven inputs into the model, then advance to the sample point
  task automatic tick();
    bit do_push = (host_push || eng_push) && q.size() < 32;
    bit do_pop  = (host_pop || eng_pop) && q.size() > 0;
    logic [15:0] d = host_push ? host_wdata : eng_wdata;
    if (cfg_we) begin
      m_rx_en = cfg_wdata[15]; m_hi = int'(cfg_wdata[12:8]);
      m_tx_en = cfg_wdata[7];  m_lo = int'(cfg_wdata[4:0]);
    end
    if (do_pop) void'(q.pop_front());
    if (do_push) q.push_back(d);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic write_cfg(logic [15:0] v);
    cfg_we = 1; cfg_wdata = v; tick();
  endtask

  task automatic hpush(logic [15:0] v);
    host_push = 1; host_wdata = v; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] h;
    void'($urandom(32'd2024));
    idle_inputs();
    cfg_wdata = 0; host_wdata = 0; eng_wdata = 0;
    xfer_active = 0; xfer_rd = 0;
    m_rx_en = 0; m_tx_en = 0; m_hi = 31; m_lo = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 count", fill_count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 cfg", cfg_rdata, 16'h1F00);
    chk("R1 levels", {rx_dma_req, tx_dma_req, af_flag, ae_flag}, 0);

    // R5 layout, unused bits ignored
    write_cfg(16'hFFFF);
    chk("R5 readback all ones", cfg_rdata, 16'h9F9F);
    write_cfg(16'h1F00);
    check_all("R5 restore");

    // R8 idle, R7 low-water flag then DMA switch
    write_cfg(16'h0005);
    check_all("R8 idle empty");
    chk("R8 quiet", {rx_dma_req, tx_dma_req, af_flag, ae_flag}, 0);
    xfer_active = 1; xfer_rd = 0; @(negedge clk);
    chk("R7 ae_flag set", ae_flag, 1);
    chk("R9 rx side low", {rx_dma_req, af_flag}, 0);
    write_cfg(16'h0085);
    chk("R7 ae_flag cleared by enable", ae_flag, 0);
    chk("R7 tx_req raised", tx_dma_req, 1);

    // R11 host priority on simultaneous push
    host_push = 1; host_wdata = 16'hAAAA; eng_push = 1; eng_wdata = 16'h5555; tick();
    chk("R11 one word", fill_count, 1);
    chk("R11 host data", head_data, 16'hAAAA);
    host_pop = 1; eng_pop = 1; tick();
    chk("R11 one pop", fill_count, 0);

    // R3 fill to 32, overflow push dropped
    for (int i = 0; i < 32; i++) hpush(16'h1000 + 16'(i));
    check_all("R3 full");
    hpush(16'hDEAD);
    chk("R3 count held", fill_count, 32);
    chk("R3 head kept", head_data, 16'h1000);
    // R10 push+pop while full: push dropped, pop taken
    host_pop = 1; eng_push = 1; eng_wdata = 16'hBEEF; tick();
    check_all("R10 full push+pop");
    // R6 high-water: card to host, level 30
    xfer_rd = 1; write_cfg(16'h1E00);
    chk("R6 af_flag", af_flag, 1);
    write_cfg(16'h9E00);
    chk("R6 af_flag cleared by enable", af_flag, 0);
    chk("R6 rx_req", rx_dma_req, 1);
    chk("R9 tx side low", {tx_dma_req, ae_flag}, 0);

    // drain, checking order (R2)
    while (q.size() > 0) begin eng_pop = 1; tick(); check_all("R2 drain"); end
    xfer_active = 0; @(negedge clk);
    check_all("R8 drained idle");

    // R4 pop while empty
    h = head_data;
    host_pop = 1; tick();
    chk("R4 count", fill_count, 0);
    chk("R4 head unchanged", head_data, h);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) begin cfg_we = 1; cfg_wdata = 16'($urandom); end
      if ($urandom_range(0, 31) == 0) xfer_active = ~xfer_active;
      if ($urandom_range(0, 63) == 0) xfer_rd = ~xfer_rd;
      host_push = ($urandom_range(0, 2) == 0); host_wdata = 16'($urandom);
      eng_push  = ($urandom_range(0, 3) == 0); eng_wdata  = 16'($urandom);
      host_pop  = ($urandom_range(0, 3) == 0);
      eng_pop   = ($urandom_range(0, 4) == 0);
      tick();
      check_all("R10 random");
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule